// File: doc/BRIEF.md
# Dual-Tone Alert Guard-Time Qualifier

This block decides whether a two-tone alert on a phone line is real. Two upstream detectors each raise a flag while their tone is present. The alert pair is 2130 Hz and 2750 Hz. The detectors are expected to accept a tone that is off-frequency by 1.1% or less and to reject one that is off by 3.5% or more. This block does no filtering and no level measurement. It only combines the two flags in time.

When both flags are high together, the early-detect output goes high. A saturating up/down counter then integrates the early-detect output in millisecond ticks. The ticks are divided down from the system clock. The steady-detect output sets once the count reaches a programmable upper threshold. It clears only when the count has fallen to a programmable lower threshold. Short dropouts of either tone, or short glitches, therefore do not disturb a qualified alert.

The block also merges three sources into one active-low interrupt: a ring-detect input, a data-ready input and the steady-detect result. A power-down input clears the integrator and silences every output.

Top module: `dual_tone_qualifier`

## Requirements
- R1: While reset is held, and afterwards with the tone flags low, `early_det` and `steady_det` are 0. `irq_n` is 1 while `ring_n` and `data_rdy_n` are both 1.
- R2: `early_det` is 1 in the cycle after a clock edge that samples `tone_lo` and `tone_hi` both 1 with `pwr_dn` 0. In all other cases it is 0 in that cycle.
- R3: The guard count moves only on a tick, and a tick occurs once every `TICK_DIV` clocks. On a tick the count goes up by 1 if `early_det` is 1 and down by 1 if it is 0.
- R4: The guard count saturates: it never exceeds `CNT_MAX` and never goes below 0. It does not wrap.
- R5: `steady_det` becomes 1 one cycle after the guard count is at least `thr_set`.
- R6: Once set, `steady_det` stays 1 until the guard count is at or below `thr_clr`. It becomes 0 one cycle later. Dropouts shorter than the count margin are bridged. `thr_clr` must be below `thr_set`.
- R7: `irq_n` is 0 whenever `ring_n` is 0, or `data_rdy_n` is 0, or `steady_det` is 1. Otherwise it is 1.
- R8: While `pwr_dn` is 1, the following hold:
  - the guard count and the tick prescaler are cleared;
  - `early_det` and `steady_det` are 0 from the next cycle on;
  - `irq_n` is 1 regardless of the other sources.
- R9: A single tone flag alone has no effect. `early_det` stays 0 and the guard count does not grow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down, active high |
| tone_lo | input | 1 | Low-tone present flag |
| tone_hi | input | 1 | High-tone present flag |
| ring_n | input | 1 | Ring detect, active low |
| data_rdy_n | input | 1 | Data-ready, active low |
| thr_set | input | CW | Guard count at which steady-detect sets |
| thr_clr | input | CW | Guard count at which steady-detect clears |
| early_det | output | 1 | Both tones present (registered) |
| steady_det | output | 1 | Alert qualified after guard time |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
The tone flags are tried in four patterns: neither, low alone, high alone, and both. Each single-flag pattern is held long enough to qualify if it were wrongly accepted. A following short run of both tones then shows whether the count grew.

A long run of both tones, followed by a short gap, separates a saturating counter from one that wraps. A long gap, followed by a short run of both tones, separates clamping at zero from underflow. A short run of both tones shows that the assert threshold is not reached early.

Each interrupt source is asserted on its own. Power-down is applied with a full count, which shows that the count is cleared rather than merely hidden.

// File: rtl/dtq_pkg.sv
package dtq_pkg;
  typedef enum logic {
    GUARD_IDLE = 1'b0,
    GUARD_HELD = 1'b1
  } guard_st_e;

  localparam int unsigned IRQ_SRC_N = 3;
endpackage

// File: rtl/dtq_tick.sv
module dtq_tick #(
  parameter int unsigned TICK_DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pre_q <= '0;
    else if (clr)         pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == LAST) && !clr;

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST); // R3
endmodule

// File: rtl/dtq_pair.sv
module dtq_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic tone_lo,
  input  logic tone_hi,
  output logic both_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) both_q <= 1'b0;
    else        both_q <= tone_lo && tone_hi && !pwr_dn;
  end

  AST_PAIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_lo && tone_hi && !pwr_dn) |=> both_q); // R2
  AST_SINGLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_lo != tone_hi) |=> !both_q); // R9
endmodule

// File: rtl/dtq_guard.sv
module dtq_guard
  import dtq_pkg::*;
#(
  parameter int unsigned CW      = 8,
  parameter int unsigned CNT_MAX = (1 << CW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn,
  input  logic          tick,
  input  logic          early,
  input  logic [CW-1:0] thr_set,
  input  logic [CW-1:0] thr_clr,
  output logic          steady
);
  localparam logic [CW-1:0] TOP = CW'(CNT_MAX);

  logic [CW-1:0] cnt_q;
  guard_st_e     st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (pwr_dn) cnt_q <= '0;
    else if (tick) begin
      if (early && cnt_q != TOP)       cnt_q <= cnt_q + 1'b1;
      else if (!early && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                st_q <= GUARD_IDLE;
    else if (pwr_dn)           st_q <= GUARD_IDLE;
    else if (cnt_q >= thr_set) st_q <= GUARD_HELD;
    else if (cnt_q <= thr_clr) st_q <= GUARD_IDLE;
  end

  assign steady = (st_q == GUARD_HELD);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP); // R4
  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pwr_dn) |=> $stable(cnt_q)); // R3
  AST_SET_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= thr_set && !pwr_dn) |=> steady); // R5
  AST_HOLD_ABOVE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && cnt_q > thr_clr && !pwr_dn) |=> steady); // R6
  AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (cnt_q == '0 && !steady)); // R8
endmodule

// File: rtl/dtq_irq.sv
module dtq_irq #(
  parameter int unsigned NSRC = 3
) (
  input  logic            pwr_dn,
  input  logic [NSRC-1:0] req,
  output logic            irq_n
);
  logic [NSRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NSRC; i++) begin : g_or
    assign chain[i+1] = chain[i] | req[i];
  end
  assign irq_n = pwr_dn | ~chain[NSRC];
endmodule

// File: rtl/dual_tone_qualifier.sv
module dual_tone_qualifier
  import dtq_pkg::*;
#(
  parameter int unsigned TICK_DIV = 200000,
  parameter int unsigned CW       = 8,
  parameter int unsigned CNT_MAX  = (1 << CW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn,
  input  logic          tone_lo,
  input  logic          tone_hi,
  input  logic          ring_n,
  input  logic          data_rdy_n,
  input  logic [CW-1:0] thr_set,
  input  logic [CW-1:0] thr_clr,
  output logic          early_det,
  output logic          steady_det,
  output logic          irq_n
);
  logic tick;
  logic [IRQ_SRC_N-1:0] req;

  dtq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .tick(tick)
  );

  dtq_pair u_pair (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
    .tone_lo(tone_lo), .tone_hi(tone_hi), .both_q(early_det)
  );

  dtq_guard #(.CW(CW), .CNT_MAX(CNT_MAX)) u_guard (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tick(tick),
    .early(early_det), .thr_set(thr_set), .thr_clr(thr_clr),
    .steady(steady_det)
  );

  assign req = {~ring_n, ~data_rdy_n, steady_det};

  dtq_irq #(.NSRC(IRQ_SRC_N)) u_irq (
    .pwr_dn(pwr_dn), .req(req), .irq_n(irq_n)
  );

  AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!early_det && !steady_det)); // R8
endmodule

// File: tb/dual_tone_qualifier_bench.sv
module dual_tone_qualifier_bench;
  localparam int unsigned TICK_DIV = 4;
  localparam int unsigned CW = 3;
  localparam int unsigned CNT_MAX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_dn = 1'b0, tone_lo = 1'b0, tone_hi = 1'b0;
  logic ring_n = 1'b1, data_rdy_n = 1'b1;
  logic [CW-1:0] thr_set = 3'd3, thr_clr = 3'd1;
  logic early_det, steady_det, irq_n;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  dual_tone_qualifier #(.TICK_DIV(TICK_DIV), .CW(CW), .CNT_MAX(CNT_MAX)) u_dual_tone_qualifier (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tone_lo(tone_lo), .tone_hi(tone_hi),
    .ring_n(ring_n), .data_rdy_n(data_rdy_n), .thr_set(thr_set), .thr_clr(thr_clr),
    .early_det(early_det), .steady_det(steady_det), .irq_n(irq_n)
  );

  typedef struct packed {
    logic       lo, hi, rg_n, dr_n, pd;
    logic [7:0] hold;
    logic       e_early, e_steady, e_irq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 8'd10, 1'b0,1'b0,1'b1, 4'd1},
    '{1'b1,1'b0,1'b1,1'b1,1'b0, 8'd40, 1'b0,1'b0,1'b1, 4'd9},
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 8'd40, 1'b0,1'b0,1'b1, 4'd9},
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 8'd6,  1'b1,1'b0,1'b1, 4'd9},
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 8'd40, 1'b1,1'b1,1'b0, 4'd5},
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 8'd12, 1'b0,1'b1,1'b0, 4'd4},
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 8'd12, 1'b1,1'b1,1'b0, 4'd6},
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 8'd40, 1'b0,1'b0,1'b1, 4'd6},
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 8'd6,  1'b1,1'b0,1'b1, 4'd4},
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 8'd40, 1'b0,1'b0,1'b1, 4'd3},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2,  1'b0,1'b0,1'b0, 4'd7},
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 8'd2,  1'b0,1'b0,1'b0, 4'd7},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 8'd10, 1'b0,1'b0,1'b1, 4'd8},
    '{1'b1,1'b0,1'b1,1'b1,1'b0, 8'd3,  1'b0,1'b0,1'b1, 4'd2}
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {early,steady,irq_n} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic lo, hi, rg, dr, pd, input int hold);
    @(negedge clk);
    tone_lo = lo; tone_hi = hi; ring_n = rg; data_rdy_n = dr; pwr_dn = pd;
    repeat (hold) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", {early_det, steady_det, irq_n}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", {early_det, steady_det, irq_n}, 3'b001);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9, tag per row in message
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].lo, TBL[i].hi, TBL[i].rg_n, TBL[i].dr_n, TBL[i].pd, int'(TBL[i].hold));
      check($sformatf("R%0d row %0d", TBL[i].req, i), {early_det, steady_det, irq_n},
            {TBL[i].e_early, TBL[i].e_steady, TBL[i].e_irq});
    end

    // R8: power-down with full count clears it, and masks ring interrupt
    apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 40);
    check("R5 saturate before pd", {early_det, steady_det, irq_n}, 3'b110);
    apply(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3);
    check("R8 pd masks outputs", {early_det, steady_det, irq_n}, 3'b001);
    apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 6);
    check("R8 count cleared by pd", {early_det, steady_det, irq_n}, 3'b101);

    // R3: exact tick spacing from a cleared prescaler
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    @(negedge clk);
    pwr_dn = 1'b0; tone_lo = 1'b1; tone_hi = 1'b1;
    repeat (TICK_DIV * 3 + 2) @(posedge clk);
    @(negedge clk);
    check("R3 three ticks reach thr_set", {early_det, steady_det, irq_n}, 3'b110);

    // R6: release only after count reaches thr_clr
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 40);
    check("R6 released after long gap", {early_det, steady_det, irq_n}, 3'b001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule